// File: doc/BRIEF.md
# Strobed Clock Source Select Controller

This block is the digital control path of a synthesizer with two clock outputs, one for video and one for memory. A 4-bit video select code passes through a strobe-qualified capture register and picks one of 16 entries in a pattern table fixed by a parameter. Each entry gives the divider settings for the video PLL and a source field. The source field says whether the video output carries the PLL clock, the external clock input, the reference clock, or nothing. A 2-bit memory select code is captured on every reference clock edge with no strobe. It picks one of 4 divider entries for the memory PLL.

The video PLL dividers always follow the entry of the latched code, including pass-through codes, so the PLL stays locked at that entry's frequency while another source is on the output. Source changes go through a glitch-free switch driven by a state machine in the reference domain. In DRAIN it withdraws every source request and waits until all gates report closed. In LOCKWAIT it waits for the PLL lock input when the new source is the PLL. In ARM it requests the new source and waits for its acknowledgement. In RUN it holds the source until the latched code changes. The transitions are:

- DRAIN to LOCKWAIT when all gates are closed.
- LOCKWAIT to RUN for the no-output source.
- LOCKWAIT to ARM once the source is ready.
- ARM to RUN on acknowledgement.
- LOCKWAIT, ARM or RUN to DRAIN on a code change.

Each source has a gate. The gate resynchronises its request in the source's own domain and opens or closes on that clock's falling edge. A one-cycle change pulse reports any change of the latched video code or of the memory code.

Top module: `clksel_ctrl`

## Requirements
- R1: While `strobe` is high at a `ref_clk` rising edge, the latched video code takes `vsel` at that edge. `vpll_fb`/`vpll_post` show the new entry after that edge.
- R2: While `strobe` is low, changes on `vsel` have no effect on the video dividers, the output source or `freq_chg`.
- R3: After reset, the latched video code and the memory code are 0. The divider outputs show entries 0 (video fb 16, post 0; memory fb 40, post 0), `freq_chg` is 0, and `vclk_out` stays low until the switch enables a source.
- R4: The memory code takes `msel` at every `ref_clk` rising edge with no strobe. The memory entry j gives fb = 40+7j and post = j, with fb in bits [9:3] and post in bits [2:0].
- R5: Video entry i gives fb = 16+5i and post = i mod 4. Its source is: code 13 none, code 14 external, code 15 reference, every other code PLL. The entry layout is source [11:10] (00 PLL, 01 external, 10 reference, 11 none), fb [9:3], post [2:0]. The video dividers always come from the latched code's entry.
- R6: For an external-source code, `vclk_out` follows `ext_clk` within 40 reference cycles. The video dividers keep that code's values (code 14: fb 86, post 2).
- R7: For a reference-source code, `vclk_out` follows `ref_clk` within 40 cycles (code 15: fb 91, post 3).
- R8: `freq_chg` is high for exactly one cycle, after the second rising edge following a stimulus that changes the latched video code or the memory code. It is low otherwise.
- R9: When the PLL is the new source, `vclk_out` stays low until `vpll_lock` is high. Within 40 cycles after that it follows `vpll_clk`.
- R10: At most one source gate is open at any time. `vclk_out` never produces a high or low phase shorter than the shortest half period of the clocks involved.
- R11: A code whose source is none (code 13) holds `vclk_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; control domain and pass-through source |
| rst_n | input | 1 | Power-on clear, active low, asynchronous |
| strobe | input | 1 | High lets the video select pass into the latch |
| vsel | input | 4 | Video frequency select code |
| msel | input | 2 | Memory frequency select code |
| ext_clk | input | 1 | External clock for pass-through |
| vpll_clk | input | 1 | Video PLL output clock |
| vpll_lock | input | 1 | Video PLL lock indication |
| vpll_fb | output | 7 | Video PLL feedback divider |
| vpll_post | output | 3 | Video PLL post divider |
| mpll_fb | output | 7 | Memory PLL feedback divider |
| mpll_post | output | 3 | Memory PLL post divider |
| freq_chg | output | 1 | One-cycle pulse on a select change |
| vclk_out | output | 1 | Glitch-free video clock output |

## Verification
The divider outputs are due one rising edge after a stimulus applied at a falling edge, and `freq_chg` is due exactly one edge later still. Each task therefore drives at a falling edge and samples one time unit after the first and second rising edges that follow. It also samples after the third edge, to see the pulse drop. The source switch crosses several synchronisers, so the output is judged only after a 40-cycle settling wait. The output is then compared against the expected clock at odd time steps, where no clock edge falls. A monitor measures every phase of `vclk_out` across all switches.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int FB_W    = 7;
    localparam int POST_W  = 3;
    localparam int SRC_W   = 2;
    localparam int VENT_W  = SRC_W + FB_W + POST_W;
    localparam int MENT_W  = FB_W + POST_W;
    localparam int NSRC    = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_PLL  = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_REF  = 2'b10,
        SRC_NONE = 2'b11
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [FB_W-1:0]   fb;
        logic [POST_W-1:0] post;
    } ventry_t;

    typedef struct packed {
        logic [FB_W-1:0]   fb;
        logic [POST_W-1:0] post;
    } mentry_t;

    function automatic logic [16*VENT_W-1:0] default_vtable();
        logic [16*VENT_W-1:0] t;
        ventry_t e;
        t = '0;
        for (int i = 0; i < 16; i++) begin
            e.src  = (i == 13) ? SRC_NONE : (i == 14) ? SRC_EXT :
                     (i == 15) ? SRC_REF  : SRC_PLL;
            e.fb   = FB_W'(16 + 5 * i);
            e.post = POST_W'(i % 4);
            t[i*VENT_W +: VENT_W] = e;
        end
        return t;
    endfunction

    function automatic logic [4*MENT_W-1:0] default_mtable();
        logic [4*MENT_W-1:0] t;
        mentry_t e;
        t = '0;
        for (int j = 0; j < 4; j++) begin
            e.fb   = FB_W'(40 + 7 * j);
            e.post = POST_W'(j);
            t[j*MENT_W +: MENT_W] = e;
        end
        return t;
    endfunction

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_leg.sv
module clksel_leg #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic en
);
    logic req_s;

    clksel_sync #(.STAGES(STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req),
        .q    (req_s)
    );

    // Gate changes only while this clock is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en <= 1'b0;
        else        en <= req_s;
    end
endmodule

// File: rtl/clksel_code_path.sv
module clksel_code_path
    import clksel_pkg::*;
#(
    parameter int VSEL_W = 4,
    parameter int MSEL_W = 2,
    parameter logic [(2**VSEL_W)*VENT_W-1:0] VTABLE = default_vtable(),
    parameter logic [(2**MSEL_W)*MENT_W-1:0] MTABLE = default_mtable()
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [VSEL_W-1:0] vsel,
    input  logic [MSEL_W-1:0] msel,
    output logic [VSEL_W-1:0] vcode,
    output logic [MSEL_W-1:0] mcode,
    output logic [FB_W-1:0]   vpll_fb,
    output logic [POST_W-1:0] vpll_post,
    output logic [FB_W-1:0]   mpll_fb,
    output logic [POST_W-1:0] mpll_post,
    output logic              freq_chg
);
    logic [VSEL_W-1:0] vprev;
    logic [MSEL_W-1:0] mprev;
    ventry_t           vent;
    mentry_t           ment;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            vcode    <= '0;
            mcode    <= '0;
            vprev    <= '0;
            mprev    <= '0;
            freq_chg <= 1'b0;
        end else begin
            if (strobe) vcode <= vsel;
            mcode    <= msel;
            vprev    <= vcode;
            mprev    <= mcode;
            freq_chg <= (vcode != vprev) || (mcode != mprev);
        end
    end

    always_comb begin
        vent      = ventry_t'(VTABLE[vcode*VENT_W +: VENT_W]);
        ment      = mentry_t'(MTABLE[mcode*MENT_W +: MENT_W]);
        vpll_fb   = vent.fb;
        vpll_post = vent.post;
        mpll_fb   = ment.fb;
        mpll_post = ment.post;
    end
endmodule

// File: rtl/clksel_switch_fsm.sv
module clksel_switch_fsm
    import clksel_pkg::*;
#(
    parameter int VSEL_W = 4,
    parameter logic [(2**VSEL_W)*VENT_W-1:0] VTABLE = default_vtable()
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [VSEL_W-1:0] vcode,
    input  logic              vpll_lock,
    input  logic [NSRC-1:0]   ack,
    output logic [NSRC-1:0]   req
);
    typedef enum logic [1:0] {
        ST_DRAIN    = 2'd0,
        ST_LOCKWAIT = 2'd1,
        ST_ARM      = 2'd2,
        ST_RUN      = 2'd3
    } state_e;

    state_e            state, state_nx;
    logic [VSEL_W-1:0] cur_q;
    ventry_t           cur_ent;
    src_e              tgt;
    logic [NSRC-1:0]   tgt_vec;
    logic              code_moved;

    always_comb begin
        cur_ent    = ventry_t'(VTABLE[cur_q*VENT_W +: VENT_W]);
        tgt        = cur_ent.src;
        code_moved = (vcode != cur_q);
        for (int k = 0; k < NSRC; k++) tgt_vec[k] = (int'(tgt) == k);
    end

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DRAIN;
            cur_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_DRAIN) cur_q <= vcode;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DRAIN:    if (ack == '0) state_nx = ST_LOCKWAIT;
            ST_LOCKWAIT: begin
                if (code_moved)                       state_nx = ST_DRAIN;
                else if (tgt == SRC_NONE)             state_nx = ST_RUN;
                else if (tgt != SRC_PLL || vpll_lock) state_nx = ST_ARM;
            end
            ST_ARM: begin
                if (code_moved)              state_nx = ST_DRAIN;
                else if (|(ack & tgt_vec))   state_nx = ST_RUN;
            end
            ST_RUN:      if (code_moved) state_nx = ST_DRAIN;
        endcase
    end

    // Outputs
    always_comb begin
        req = '0;
        if (state == ST_ARM || state == ST_RUN) req = tgt_vec;
    end
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int VSEL_W      = 4,
    parameter int MSEL_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter logic [(2**VSEL_W)*VENT_W-1:0] VTABLE = default_vtable(),
    parameter logic [(2**MSEL_W)*MENT_W-1:0] MTABLE = default_mtable()
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [VSEL_W-1:0] vsel,
    input  logic [MSEL_W-1:0] msel,
    input  logic              ext_clk,
    input  logic              vpll_clk,
    input  logic              vpll_lock,
    output logic [FB_W-1:0]   vpll_fb,
    output logic [POST_W-1:0] vpll_post,
    output logic [FB_W-1:0]   mpll_fb,
    output logic [POST_W-1:0] mpll_post,
    output logic              freq_chg,
    output logic              vclk_out
);
    logic [VSEL_W-1:0] vcode;
    logic [MSEL_W-1:0] mcode;
    logic [NSRC-1:0]   src_clk;
    logic [NSRC-1:0]   leg_req;
    logic [NSRC-1:0]   leg_en;
    logic [NSRC-1:0]   leg_ack;

    assign src_clk = {ref_clk, ext_clk, vpll_clk};

    clksel_code_path #(
        .VSEL_W(VSEL_W), .MSEL_W(MSEL_W), .VTABLE(VTABLE), .MTABLE(MTABLE)
    ) u_code (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .vsel     (vsel),
        .msel     (msel),
        .vcode    (vcode),
        .mcode    (mcode),
        .vpll_fb  (vpll_fb),
        .vpll_post(vpll_post),
        .mpll_fb  (mpll_fb),
        .mpll_post(mpll_post),
        .freq_chg (freq_chg)
    );

    clksel_switch_fsm #(.VSEL_W(VSEL_W), .VTABLE(VTABLE)) u_fsm (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .vcode    (vcode),
        .vpll_lock(vpll_lock),
        .ack      (leg_ack),
        .req      (leg_req)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        clksel_leg #(.STAGES(SYNC_STAGES)) u_leg (
            .clk  (src_clk[k]),
            .rst_n(rst_n),
            .req  (leg_req[k]),
            .en   (leg_en[k])
        );
        clksel_sync #(.STAGES(SYNC_STAGES)) u_ack (
            .clk  (ref_clk),
            .rst_n(rst_n),
            .d    (leg_en[k]),
            .q    (leg_ack[k])
        );
    end

    assign vclk_out = |(src_clk & leg_en);
endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk
    import clksel_pkg::*;
#(
    parameter int VSEL_W = 4,
    parameter int MSEL_W = 2,
    parameter logic [(2**MSEL_W)*MENT_W-1:0] MTABLE = default_mtable()
) (
    input logic              ref_clk,
    input logic              rst_n,
    input logic              strobe,
    input logic [VSEL_W-1:0] vsel,
    input logic [MSEL_W-1:0] msel,
    input logic [VSEL_W-1:0] vcode,
    input logic [MSEL_W-1:0] mcode,
    input logic [FB_W-1:0]   vpll_fb,
    input logic [POST_W-1:0] vpll_post,
    input logic [FB_W-1:0]   mpll_fb,
    input logic [POST_W-1:0] mpll_post,
    input logic              freq_chg,
    input logic [NSRC-1:0]   leg_en
);
    logic [1:0] age_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    function automatic logic [MENT_W-1:0] ment_of(input logic [MSEL_W-1:0] j);
        return MTABLE[j*MENT_W +: MENT_W];
    endfunction

    a_r1_strobe_follow: assert property (@(posedge ref_clk) disable iff (!rst_n)
        strobe |=> (vcode == $past(vsel)));

    a_r2_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !strobe |=> ($stable(vcode) && $stable(vpll_fb) && $stable(vpll_post)));

    a_r4_mem_follow: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (age_q != 2'd0) |-> ({mpll_fb, mpll_post} == ment_of($past(msel))));

    a_r8_chg_detect: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (freq_chg == (($past(vcode, 1) != $past(vcode, 2)) ||
                                          ($past(mcode, 1) != $past(mcode, 2)))));

    a_r10_one_source: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $onehot0(leg_en));
endmodule

bind clksel_ctrl clksel_ctrl_chk #(
    .VSEL_W(VSEL_W), .MSEL_W(MSEL_W), .MTABLE(MTABLE)
) u_chk (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .vsel     (vsel),
    .msel     (msel),
    .vcode    (vcode),
    .mcode    (mcode),
    .vpll_fb  (vpll_fb),
    .vpll_post(vpll_post),
    .mpll_fb  (mpll_fb),
    .mpll_post(mpll_post),
    .freq_chg (freq_chg),
    .leg_en   (leg_en)
);

// File: tb/clksel_ctrl_tb.sv
module clksel_ctrl_tb_top;
    localparam int CLK_PERIOD = 20;
    localparam int VPLL_PERIOD = 12;
    localparam int EXT_PERIOD = 28;
    localparam int SETTLE = 40;

    logic       ref_clk = 1'b0;
    logic       ext_clk = 1'b0;
    logic       vpll_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [3:0] vsel = 4'd5;
    logic [1:0] msel = 2'd0;
    logic       vpll_lock = 1'b0;
    logic [6:0] vpll_fb, mpll_fb;
    logic [2:0] vpll_post, mpll_post;
    logic       freq_chg, vclk_out;

    int total = 0;
    int bad = 0;
    int glitches = 0;
    bit mon_on = 0;
    longint last_edge = -1;

    always #(CLK_PERIOD/2)  ref_clk  = ~ref_clk;
    always #(VPLL_PERIOD/2) vpll_clk = ~vpll_clk;
    always #(EXT_PERIOD/2)  ext_clk  = ~ext_clk;

    clksel_ctrl dut_i (
        .ref_clk(ref_clk), .rst_n(rst_n), .strobe(strobe), .vsel(vsel), .msel(msel),
        .ext_clk(ext_clk), .vpll_clk(vpll_clk), .vpll_lock(vpll_lock),
        .vpll_fb(vpll_fb), .vpll_post(vpll_post), .mpll_fb(mpll_fb),
        .mpll_post(mpll_post), .freq_chg(freq_chg), .vclk_out(vclk_out)
    );

    // R10: every phase of vclk_out must last at least the shortest half period (6).
    always @(vclk_out) begin
        if (mon_on) begin
            if (last_edge >= 0 && ($time - last_edge) < VPLL_PERIOD/2) glitches++;
            last_edge = $time;
        end
    end

    function automatic int exp_vfb(input int i);   return 16 + 5 * i;  endfunction
    function automatic int exp_vpost(input int i); return i % 4;       endfunction
    function automatic int exp_mfb(input int j);   return 40 + 7 * j;  endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge ref_clk);
    endtask

    // src: 0 PLL, 1 external, 2 reference, 3 none (low)
    task automatic check_follow(input int src, input string req);
        int mism = 0;
        @(posedge ref_clk);
        #1;
        for (int s = 0; s < 150; s++) begin
            logic e;
            case (src)
                0:       e = vpll_clk;
                1:       e = ext_clk;
                2:       e = ref_clk;
                default: e = 1'b0;
            endcase
            if (vclk_out !== e) mism++;
            #2;
        end
        chk(req, mism, 0);
    endtask

    // Drive a video code with strobe, check the divider and pulse timing.
    task automatic load_code(input int code, input bit lock_v, input string req);
        @(negedge ref_clk);
        strobe = 1'b1;
        vsel = 4'(code);
        vpll_lock = lock_v;
        @(posedge ref_clk); #1;
        chk({req, " R1 R5 fb"}, int'(vpll_fb), exp_vfb(code));
        chk({req, " R1 R5 post"}, int'(vpll_post), exp_vpost(code));
        chk("R8 no early pulse", int'(freq_chg), 0);
        @(posedge ref_clk); #1;
        chk("R8 pulse high", int'(freq_chg), 1);
        @(posedge ref_clk); #1;
        chk("R8 pulse one cycle", int'(freq_chg), 0);
        @(negedge ref_clk);
        strobe = 1'b0;
    endtask

    task automatic t_reset();
        chk("R3 vfb", int'(vpll_fb), 16);
        chk("R3 vpost", int'(vpll_post), 0);
        chk("R3 mfb", int'(mpll_fb), 40);
        chk("R3 mpost", int'(mpll_post), 0);
        chk("R3 freq_chg", int'(freq_chg), 0);
        wait_cycles(SETTLE);
        check_follow(3, "R3 R9 output low without lock");
    endtask

    task automatic t_lock_release();
        @(negedge ref_clk);
        vpll_lock = 1'b1;
        wait_cycles(SETTLE);
        check_follow(0, "R9 follows PLL after lock");
    endtask

    task automatic t_pll_code();
        load_code(3, 1'b0, "R9 code3");
        wait_cycles(SETTLE);
        check_follow(3, "R9 low while unlocked");
        @(negedge ref_clk);
        vpll_lock = 1'b1;
        wait_cycles(SETTLE);
        check_follow(0, "R5 R9 PLL code3");
    endtask

    task automatic t_hold();
        int pulses = 0;
        @(negedge ref_clk);
        strobe = 1'b0;
        vsel = 4'd14;
        for (int c = 0; c < SETTLE; c++) begin
            @(posedge ref_clk); #1;
            if (freq_chg) pulses++;
        end
        chk("R2 no pulse", pulses, 0);
        chk("R2 fb held", int'(vpll_fb), exp_vfb(3));
        chk("R2 post held", int'(vpll_post), exp_vpost(3));
        check_follow(0, "R2 source held");
    endtask

    task automatic t_mem(input int j);
        @(negedge ref_clk);
        msel = 2'(j);
        @(posedge ref_clk); #1;
        chk("R4 mfb", int'(mpll_fb), exp_mfb(j));
        chk("R4 mpost", int'(mpll_post), j);
        chk("R8 mem no early pulse", int'(freq_chg), 0);
        @(posedge ref_clk); #1;
        chk("R8 mem pulse", int'(freq_chg), 1);
        @(posedge ref_clk); #1;
        chk("R8 mem pulse one cycle", int'(freq_chg), 0);
    endtask

    task automatic t_ext();
        load_code(14, 1'b1, "R6 code14");
        wait_cycles(SETTLE);
        check_follow(1, "R6 follows ext");
        chk("R6 PLL fb kept", int'(vpll_fb), 86);
        chk("R6 PLL post kept", int'(vpll_post), 2);
    endtask

    task automatic t_ref();
        load_code(15, 1'b1, "R7 code15");
        wait_cycles(SETTLE);
        check_follow(2, "R7 follows ref");
        chk("R7 fb", int'(vpll_fb), 91);
    endtask

    task automatic t_none();
        load_code(13, 1'b1, "R11 code13");
        wait_cycles(SETTLE);
        check_follow(3, "R11 output low");
    endtask

    initial begin
        wait_cycles(3);
        @(negedge ref_clk);
        rst_n = 1'b1;
        mon_on = 1;
        @(posedge ref_clk); #1;
        t_reset();
        t_lock_release();
        t_pll_code();
        t_hold();
        t_mem(2);
        t_mem(3);
        t_ext();
        t_ref();
        t_none();
        load_code(7, 1'b0, "R9 code7");
        wait_cycles(SETTLE);
        check_follow(3, "R9 code7 low while unlocked");
        @(negedge ref_clk);
        vpll_lock = 1'b1;
        wait_cycles(SETTLE);
        check_follow(0, "R9 code7 PLL");
        chk("R10 no short phase", glitches, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule